// File: doc/BRIEF.md
# I2C SCL Bit-Rate Tick Generator

This block turns the system clock into the timing base for an I2C master's SCL line. A small mode field enables the generator, picks a power-of-two predivider and adds an optional input-filter allowance. An 8-bit divider value sets the remaining count. Each time a half SCL period has elapsed, the block raises a single-cycle tick, and it toggles a free-running SCL phase level at the same edge. The protocol engine uses the tick to move its bit-level state and the phase to drive or sample SCL.

The length of a half period, in system clocks, is the predivide factor times (divider + 3 + 2 × filter). The predivide factor is 32, 16, 8 or 4. A full SCL period is twice that length, so the duty cycle is 50%. A new setting takes effect only at a full-period boundary, or while the generator is disabled. A period therefore never mixes two rates.

Top module: `scl_rate_gen`

## Requirements
- R1: The predivider select is mode bits [2:1]. Its value s gives a predivide factor of 1 << (5 - s): 32, 16, 8 and 4 for s = 0, 1, 2, 3.
- R2: With the generator enabled, consecutive half_tick pulses are exactly factor × (div + 3 + 2 × f) clocks apart. Here div is the 8-bit divider input and f is mode bit 3.
- R3: scl_phase changes value in exactly the cycles in which half_tick is high while enabled, so high and low phases have equal length.
- R4: Mode bit 0 is the enable. While it is sampled low, half_tick and scl_phase are 0 and all counts clear. After enable rises, the first half_tick appears after a full half period of enabled clocks. Both outputs are registered.
- R5: The settings (select, filter, divider) are captured on every disabled clock and at each full-period boundary, that is, the edge where scl_phase goes from 1 to 0. A change at any other time has no effect on timing until the next such boundary.
- R6: Divider values 0 and 255 both give a half period matching R2.
- R7: half_tick is never high for two consecutive cycles, and never high on the clock after a disabled clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 4 | bit0 enable, bits[2:1] predivider select, bit3 filter |
| div_i | input | 8 | Divider value 0..255 |
| half_tick_o | output | 1 | One-cycle pulse at each SCL half-period boundary |
| scl_phase_o | output | 1 | SCL phase level, toggles on each tick |

## Verification
A behavioural reference model runs on a single elapsed-cycle counter and is compared against the outputs on every clock. Stimulus first sweeps all four predivider selects at a small divider, which separates the factor decoding from the additive term. It then sets the filter bit at divider 0, and runs the divider at 0 and 255 to expose offset and width errors at both ends. It toggles the enable in the middle of a period to check that the counts clear, and rewrites the settings while scl_phase is high and while it is low to distinguish full-period from half-period or immediate capture.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;
   // bit positions inside the mode field; the protocol side decodes these
   localparam int MODE_EN_BIT   = 0;
   localparam int MODE_SEL_LSB  = 1;
   localparam int MODE_FILT_OFS = 2; // offset above the select field

   // terminal count of the predivider for a given select value
   function automatic int unsigned pre_limit(input int unsigned exp_top,
                                             input int unsigned sel);
      return (32'd1 << (exp_top - sel)) - 32'd1;
   endfunction
endpackage

// File: rtl/scl_cfg_hold.sv
module scl_cfg_hold #(
   parameter int SEL_W     = 2,
   parameter int DIV_W     = 8,
   parameter bit FILTER_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             filt_i,
   input  logic [DIV_W-1:0] div_i,
   output logic [SEL_W-1:0] sel_o,
   output logic             filt_o,
   output logic [DIV_W-1:0] div_o
);
   logic [SEL_W-1:0] sel_q;
   logic [DIV_W-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         div_q <= '0;
      end else if (load_i) begin
         sel_q <= sel_i;
         div_q <= div_i;
      end
   end

   generate
      if (FILTER_EN) begin : g_filt
         logic filt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      filt_q <= 1'b0;
            else if (load_i) filt_q <= filt_i;
         end
         assign filt_o = filt_q;
      end else begin : g_nofilt
         assign filt_o = 1'b0;
      end
   endgenerate

   assign sel_o = sel_q;
   assign div_o = div_q;

   // R5: settings move only when a load is requested
   p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> ($stable(div_o) && $stable(sel_o)));
endmodule

// File: rtl/scl_prescale.sv
module scl_prescale #(
   parameter int SEL_W   = 2,
   parameter int EXP_TOP = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             wrap_o
);
   import scl_rate_pkg::*;
   localparam int CNT_W = EXP_TOP + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim;

   always_comb begin
      lim = CNT_W'(pre_limit(EXP_TOP, 32'(sel_i)));
   end

   assign wrap_o = run_i && (cnt_q == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!run_i) cnt_q <= '0;
      else if (wrap_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end

   // R1: count never passes the terminal value of the selected factor
   p_pre_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      run_i |-> (cnt_q <= lim));
endmodule

// File: rtl/scl_half_cnt.sv
module scl_half_cnt #(
   parameter int DIV_W    = 8,
   parameter int BASE_ADD = 3,
   parameter int FILT_ADD = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             step_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic             filt_i,
   output logic             wrap_o
);
   localparam int H_W = DIV_W + 2;

   logic [H_W-1:0] cnt_q;
   logic [H_W-1:0] lim;

   always_comb begin
      lim = H_W'(div_i) + H_W'(BASE_ADD) - H_W'(1);
      if (filt_i) lim = lim + H_W'(FILT_ADD);
   end

   assign wrap_o = run_i && step_i && (cnt_q == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!run_i) cnt_q <= '0;
      else if (wrap_o) cnt_q <= '0;
      else if (step_i) cnt_q <= cnt_q + 1'b1;
   end

   // R2: count stays inside the half-period span
   p_half_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      run_i |-> (cnt_q <= lim));
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
   parameter int DIV_W     = 8,
   parameter int SEL_W     = 2,
   parameter int EXP_TOP   = 5,
   parameter int BASE_ADD  = 3,
   parameter int FILT_ADD  = 2,
   parameter bit FILTER_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SEL_W+1:0]   mode_i,
   input  logic [DIV_W-1:0]   div_i,
   output logic               half_tick_o,
   output logic               scl_phase_o
);
   import scl_rate_pkg::*;
   localparam int FILT_BIT = MODE_SEL_LSB + SEL_W - 1 + MODE_FILT_OFS - 1;

   generate
      if (EXP_TOP < (1 << SEL_W) - 1) begin : g_bad_exp
         $error("EXP_TOP too small for select width");
      end
      if (BASE_ADD < 1) begin : g_bad_base
         $error("BASE_ADD must be at least 1");
      end
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("DIV_W out of range");
      end
   endgenerate

   logic             en;
   logic             pre_wrap, half_wrap, load;
   logic [SEL_W-1:0] sel_q;
   logic             filt_q;
   logic [DIV_W-1:0] div_q;
   logic             tick_q, phase_q;

   assign en   = mode_i[MODE_EN_BIT];
   assign load = !en || (half_wrap && phase_q);

   scl_cfg_hold #(.SEL_W(SEL_W), .DIV_W(DIV_W), .FILTER_EN(FILTER_EN)) i_cfg (
      .clk(clk), .rst_n(rst_n), .load_i(load),
      .sel_i(mode_i[MODE_SEL_LSB +: SEL_W]), .filt_i(mode_i[FILT_BIT]),
      .div_i(div_i), .sel_o(sel_q), .filt_o(filt_q), .div_o(div_q));

   scl_prescale #(.SEL_W(SEL_W), .EXP_TOP(EXP_TOP)) i_pre (
      .clk(clk), .rst_n(rst_n), .run_i(en), .sel_i(sel_q), .wrap_o(pre_wrap));

   scl_half_cnt #(.DIV_W(DIV_W), .BASE_ADD(BASE_ADD), .FILT_ADD(FILT_ADD)) i_half (
      .clk(clk), .rst_n(rst_n), .run_i(en), .step_i(pre_wrap),
      .div_i(div_q), .filt_i(filt_q), .wrap_o(half_wrap));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_q  <= 1'b0;
         phase_q <= 1'b0;
      end else if (!en) begin
         tick_q  <= 1'b0;
         phase_q <= 1'b0;
      end else begin
         tick_q  <= half_wrap;
         if (half_wrap) phase_q <= !phase_q;
      end
   end

   assign half_tick_o = tick_q;
   assign scl_phase_o = phase_q;

   // R4: a disabled clock leaves both outputs low afterwards
   p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!half_tick_o && !scl_phase_o));
   // R3: phase moves with the tick and only then
   p_phase_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en) && !half_tick_o) |-> $stable(scl_phase_o));
   p_tick_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
      half_tick_o |-> !$stable(scl_phase_o));
   // R7: tick pulses are single-cycle
   p_single_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      half_tick_o |=> !half_tick_o);
endmodule

// File: tb/test_scl_rate_gen.sv
module test_scl_rate_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] mode = 4'h0;
   logic [7:0] div = 8'd0;
   logic       half_tick, scl_phase;

   int n_checks = 0;
   int n_fail   = 0;
   string cur_req = "R4";
   bit done = 1'b0;

   always #2 clk = ~clk; // 250 MHz

   scl_rate_gen i_scl_rate_gen (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .div_i(div),
      .half_tick_o(half_tick), .scl_phase_o(scl_phase));

   // reference model: one elapsed counter per half period
   int m_cnt = 0, m_p = 32, m_h = 3;
   bit m_phase = 1'b0, m_tick = 1'b0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n || !mode[0]) begin
         m_cnt = 0; m_phase = 1'b0; m_tick = 1'b0;
         if (rst_n) begin
            m_p = 1 << (5 - int'(mode[2:1]));
            m_h = int'(div) + 3 + 2 * int'(mode[3]);
         end
      end else begin
         m_tick = 1'b0;
         m_cnt++;
         if (m_cnt == m_p * m_h) begin
            m_cnt = 0;
            m_tick = 1'b1;
            if (m_phase) begin
               m_p = 1 << (5 - int'(mode[2:1]));
               m_h = int'(div) + 3 + 2 * int'(mode[3]);
            end
            m_phase = !m_phase;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_checks++;
         if (half_tick !== m_tick || scl_phase !== m_phase) begin
            n_fail++;
            $display("FAIL %s: tick=%b phase=%b expected tick=%b phase=%b",
                     cur_req, half_tick, scl_phase, m_tick, m_phase);
         end
      end
   end

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_tick();
      @(negedge clk);
      while (half_tick !== 1'b1) @(negedge clk);
   endtask

   // explicit gap between two ticks
   task automatic measure(input int exp, input string req);
      int gap;
      wait_tick();
      gap = 0;
      do begin @(negedge clk); gap++; end while (half_tick !== 1'b1 && gap < 5000);
      n_checks++;
      if (gap != exp) begin
         n_fail++;
         $display("FAIL %s: half period %0d expected %0d", req, gap, exp);
      end
   endtask

   task automatic setcfg(input bit en, input int sel, input bit f, input int d);
      mode = {f, sel[1:0], en};
      div  = d[7:0];
   endtask

   initial begin
      #20000000;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      cyc(3);
      n_checks++;
      if (half_tick !== 1'b0 || scl_phase !== 1'b0) begin
         n_fail++;
         $display("FAIL R4: reset tick=%b phase=%b expected 0 0", half_tick, scl_phase);
      end
      rst_n = 1'b1;
      cyc(2);

      // R1: all predivider selects, divider 2
      for (int s = 0; s < 4; s++) begin
         cur_req = "R1";
         setcfg(1'b0, s, 1'b0, 2); cyc(2);
         setcfg(1'b1, s, 1'b0, 2);
         measure((1 << (5 - s)) * 5, "R1");
         cyc(200);
      end

      // R2: filter adds two counts
      cur_req = "R2";
      setcfg(1'b0, 3, 1'b1, 0); cyc(2);
      setcfg(1'b1, 3, 1'b1, 0);
      measure(4 * 5, "R2");
      cyc(100);

      // R6: divider extremes
      cur_req = "R6";
      setcfg(1'b0, 0, 1'b0, 0); cyc(2);
      setcfg(1'b1, 0, 1'b0, 0);
      measure(32 * 3, "R6");
      setcfg(1'b0, 3, 1'b0, 255); cyc(2);
      setcfg(1'b1, 3, 1'b0, 255);
      measure(4 * 258, "R6");
      cyc(1100);

      // R4: disable mid period, first half period after re-enable is full
      cur_req = "R4";
      setcfg(1'b1, 3, 1'b0, 1); cyc(2);
      setcfg(1'b0, 3, 1'b0, 1); cyc(7);
      setcfg(1'b1, 3, 1'b0, 1); cyc(40);
      setcfg(1'b0, 3, 1'b0, 1); cyc(1);
      setcfg(1'b1, 3, 1'b0, 1);
      begin
         int gap = 0;
         do begin @(negedge clk); gap++; end while (half_tick !== 1'b1 && gap < 500);
         n_checks++;
         if (gap != 16) begin
            n_fail++;
            $display("FAIL R4: first tick after %0d clocks expected 16", gap);
         end
      end

      // R5: change while phase high, then while phase low
      cur_req = "R5";
      cyc(3);
      while (scl_phase !== 1'b1) @(negedge clk);
      cyc(3);
      setcfg(1'b1, 2, 1'b0, 4);
      cyc(300);
      while (scl_phase !== 1'b0) @(negedge clk);
      cyc(5);
      setcfg(1'b1, 3, 1'b1, 0);
      cyc(400);
      measure(20, "R5");

      // R3 / R7: steady run, compared every clock
      cur_req = "R3";
      setcfg(1'b1, 1, 1'b1, 7); cyc(1500);
      cur_req = "R7";
      setcfg(1'b1, 3, 1'b0, 0); cyc(200);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule